// File: doc/BRIEF.md
# Reconfigurable Datapath Processing Element

This block is one cell of a row-organised reconfigurable datapath array. Each cell pairs an integer functional unit, which combines two selected operands, with a transfer unit, which passes one selected operand through unchanged. The transfer unit lets a value skip over rows it has no business in. Any of the three operands can come from a per-cell immediate value instead of from the routed sources. The previous row's routing network delivers the candidate sources. External configuration registers supply the operand selects, the immediate value, the opcode and one of four operating modes.

The candidate sources are 2×(2·MCL+1) words laid side by side on one bus, where MCL is the largest horizontal distance a connection may span between rows. Each of the three operand selectors uses ceil(log2) of that count as its select width. All outputs are registered once, so each row of cells forms one pipeline stage, and a valid bit travels with the data.

A per-instance parameter sets the cell's kind. An add/sub cell offers the add, subtract and bitwise operations. A multiply cell offers only the multiply. The two kinds can be arranged in a checkered pattern across the array.

Top module: `pe_cell`

## Requirements
- R1: A synchronous active-low reset drives every output to zero (fu_vld_o, fu_q_o, tr_vld_o, tr_q_o, err_o) at the next clock edge, and this holds while reset stays low.
- R2: Source k occupies bits [k*DATA_W +: DATA_W] of src_i. Operand A, B or T is the source chosen by cfg_sel_a, cfg_sel_b or cfg_sel_t. When the matching cfg_imm_a/b/t bit is 1, cfg_imm takes the place of that source.
- R3: A select value equal to or above the source count (10 with default parameters) with its immediate bit at 0 yields an all-zero operand.
- R4: In an add/sub cell (KIND=0), opcode 0 gives A+B, 1 gives A−B, 2 gives A&B, 3 gives A|B and 4 gives A^B, all modulo 2^DATA_W.
- R5: In a multiply cell (KIND=1), opcode 5 gives the low DATA_W bits of A×B.
- R6: An opcode the cell kind does not support, in a mode that uses the functional unit, gives fu_q_o=0 with fu_vld_o=1 and err_o=1. An add/sub cell does not support 5, 6 and 7. A multiply cell supports only 5.
- R7: Mode 0 (functional unit only) gives the result on fu_q_o and holds tr_q_o=0 with tr_vld_o=0.
- R8: Mode 1 (transfer only) gives operand T on tr_q_o with tr_vld_o=1, and gives fu_q_o=0, fu_vld_o=0 and err_o=0 whatever the opcode.
- R9: Mode 2 (functional unit plus transfer) gives the result on fu_q_o and operand T on tr_q_o, with both valid bits set.
- R10: Mode 3 (double transfer) passes operand A unchanged on fu_q_o and operand T on tr_q_o, with both valid bits set and err_o=0 whatever the opcode.
- R11: Results appear exactly one clock edge after the inputs are sampled. A cycle with in_vld=0 gives all outputs zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Sources and configuration valid this cycle |
| src_i | input | NSRC*DATA_W | Candidate sources from the previous row |
| cfg_mode | input | 2 | Operating mode (0 FU, 1 T, 2 FU+T, 3 T+T) |
| cfg_op | input | 3 | Functional unit opcode |
| cfg_sel_a | input | SEL_W | Source select for operand A |
| cfg_sel_b | input | SEL_W | Source select for operand B |
| cfg_sel_t | input | SEL_W | Source select for transfer operand |
| cfg_imm_a | input | 1 | Use immediate for operand A |
| cfg_imm_b | input | 1 | Use immediate for operand B |
| cfg_imm_t | input | 1 | Use immediate for transfer operand |
| cfg_imm | input | DATA_W | Immediate value |
| fu_vld_o | output | 1 | Functional unit output valid |
| fu_q_o | output | DATA_W | Functional unit result, or operand A in mode 3 |
| tr_vld_o | output | 1 | Transfer output valid |
| tr_q_o | output | DATA_W | Transfer output |
| err_o | output | 1 | Unsupported opcode flag |

## Verification
The assertions check on every cycle the mode-dependent output contract. They confirm that the transfer path is silent in mode 0, and that modes 1 and 3 forward exactly the operands chosen one cycle earlier with no error. They also check that an unsupported opcode yields a zero, flagged result, and that a bubble empties the stage. The directed scenarios are the only check of the arithmetic values of each opcode and of the multiply cell's wrap-around. They also cover the source bit positions, the immediate substitution, the out-of-range selects and the behaviour of reset in mid-stream.

// File: rtl/pe_cell_pkg.sv
// Package: shared mode and opcode codes for the processing element, plus
// the rule that says which opcodes each cell kind supports.
package pe_cell_pkg;

    typedef enum logic [1:0] {
        MODE_FU  = 2'd0,
        MODE_T   = 2'd1,
        MODE_FUT = 2'd2,
        MODE_TT  = 2'd3
    } pe_mode_e;

    localparam logic [2:0] OP_ADD = 3'd0;
    localparam logic [2:0] OP_SUB = 3'd1;
    localparam logic [2:0] OP_AND = 3'd2;
    localparam logic [2:0] OP_OR  = 3'd3;
    localparam logic [2:0] OP_XOR = 3'd4;
    localparam logic [2:0] OP_MUL = 3'd5;

    localparam int KIND_ADDSUB = 0;
    localparam int KIND_MUL    = 1;

    // True when the given cell kind implements the opcode.
    function automatic logic op_legal(input int kind, input logic [2:0] op);
        if (kind == KIND_MUL) return (op == OP_MUL);
        return (op <= OP_XOR);
    endfunction

endpackage

// File: rtl/pe_opsel.sv
// Operand selector: picks one of NSRC packed source words, or the immediate
// value. Assumes source k sits at bits [k*DATA_W +: DATA_W]; any select value
// beyond the last source gives zero.
module pe_opsel #(
    parameter int DATA_W = 16,
    parameter int NSRC   = 10,
    parameter int SEL_W  = 4
) (
    input  logic [NSRC*DATA_W-1:0] src,
    input  logic [SEL_W-1:0]       sel,
    input  logic                   use_imm,
    input  logic [DATA_W-1:0]      imm,
    output logic [DATA_W-1:0]      opnd
);

    // Select the operand word; zero when no source matches.
    always_comb begin
        opnd = '0;
        if (use_imm) begin
            opnd = imm;
        end else begin
            for (int k = 0; k < NSRC; k++) begin
                if (sel == SEL_W'(k)) opnd = src[k*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/pe_alu.sv
// Functional unit: A op B for one cell kind chosen by KIND. An add/sub cell
// does add, subtract and bitwise ops; a multiply cell multiplies. Unsupported
// opcodes return zero with 'bad' raised. Purely combinational.
module pe_alu
    import pe_cell_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int KIND   = KIND_ADDSUB
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [2:0]        op,
    output logic [DATA_W-1:0] res,
    output logic              bad
);

    generate
        if (KIND == KIND_MUL) begin : g_mul
            // Multiply cell: only the low half of the product.
            always_comb begin
                res = '0;
                bad = 1'b1;
                if (op == OP_MUL) begin
                    res = a * b;
                    bad = 1'b0;
                end
            end
        end else begin : g_addsub
            // Add/sub cell: arithmetic and bitwise operations.
            always_comb begin
                res = '0;
                bad = 1'b0;
                case (op)
                    OP_ADD:  res = a + b;
                    OP_SUB:  res = a - b;
                    OP_AND:  res = a & b;
                    OP_OR:   res = a | b;
                    OP_XOR:  res = a ^ b;
                    default: bad = 1'b1;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/pe_outreg.sv
// Output stage: steers the functional result and the operands onto the two
// output ports by mode, then registers them so the row is one pipe stage.
// Assumes a synchronous active-low reset; a bubble clears every output.
module pe_outreg
    import pe_cell_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  pe_mode_e          mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_t,
    input  logic [DATA_W-1:0] fu_res,
    input  logic              fu_bad,
    output logic              fu_vld_q,
    output logic [DATA_W-1:0] fu_q,
    output logic              tr_vld_q,
    output logic [DATA_W-1:0] tr_q,
    output logic              err_q
);

    logic              fu_used;
    logic              fu_vld_d, tr_vld_d, err_d;
    logic [DATA_W-1:0] fu_d, tr_d;

    // Decide what each output port carries this cycle.
    always_comb begin
        fu_used  = (mode == MODE_FU) || (mode == MODE_FUT);
        fu_vld_d = vld && (mode != MODE_T);
        tr_vld_d = vld && (mode != MODE_FU);
        err_d    = vld && fu_used && fu_bad;
        fu_d     = '0;
        tr_d     = '0;
        if (vld) begin
            if (mode == MODE_TT)       fu_d = opnd_a;
            else if (fu_used && !fu_bad) fu_d = fu_res;
            if (mode != MODE_FU)       tr_d = opnd_t;
        end
    end

    // Register the stage outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fu_vld_q <= 1'b0;
            fu_q     <= '0;
            tr_vld_q <= 1'b0;
            tr_q     <= '0;
            err_q    <= 1'b0;
        end else begin
            fu_vld_q <= fu_vld_d;
            fu_q     <= fu_d;
            tr_vld_q <= tr_vld_d;
            tr_q     <= tr_d;
            err_q    <= err_d;
        end
    end

endmodule

// File: rtl/pe_cell.sv
// Processing element top: three operand selectors (A, B, transfer), one
// functional unit of kind KIND and the registered output stage. Assumes the
// configuration inputs are held stable by an external loader while in use.
module pe_cell
    import pe_cell_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MCL    = 2,
    parameter int KIND   = KIND_ADDSUB,
    localparam int NSRC  = 2 * (2 * MCL + 1),
    localparam int SEL_W = $clog2(NSRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic [NSRC*DATA_W-1:0] src_i,
    input  logic [1:0]             cfg_mode,
    input  logic [2:0]             cfg_op,
    input  logic [SEL_W-1:0]       cfg_sel_a,
    input  logic [SEL_W-1:0]       cfg_sel_b,
    input  logic [SEL_W-1:0]       cfg_sel_t,
    input  logic                   cfg_imm_a,
    input  logic                   cfg_imm_b,
    input  logic                   cfg_imm_t,
    input  logic [DATA_W-1:0]      cfg_imm,
    output logic                   fu_vld_o,
    output logic [DATA_W-1:0]      fu_q_o,
    output logic                   tr_vld_o,
    output logic [DATA_W-1:0]      tr_q_o,
    output logic                   err_o
);

    localparam int NOPND = 3;

    logic [NOPND-1:0][SEL_W-1:0]  sel_v;
    logic [NOPND-1:0]             imm_v;
    logic [NOPND-1:0][DATA_W-1:0] opnd_v;
    logic [DATA_W-1:0]            opnd_a, opnd_b, opnd_t;
    logic [DATA_W-1:0]            fu_res;
    logic                         fu_bad;

    assign sel_v  = {cfg_sel_t, cfg_sel_b, cfg_sel_a};
    assign imm_v  = {cfg_imm_t, cfg_imm_b, cfg_imm_a};
    assign opnd_a = opnd_v[0];
    assign opnd_b = opnd_v[1];
    assign opnd_t = opnd_v[2];

    generate
        for (genvar g = 0; g < NOPND; g++) begin : g_sel
            pe_opsel #(.DATA_W(DATA_W), .NSRC(NSRC), .SEL_W(SEL_W)) i_sel (
                .src     (src_i),
                .sel     (sel_v[g]),
                .use_imm (imm_v[g]),
                .imm     (cfg_imm),
                .opnd    (opnd_v[g])
            );
        end
    endgenerate

    pe_alu #(.DATA_W(DATA_W), .KIND(KIND)) i_alu (
        .a   (opnd_a),
        .b   (opnd_b),
        .op  (cfg_op),
        .res (fu_res),
        .bad (fu_bad)
    );

    pe_outreg #(.DATA_W(DATA_W)) i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (in_vld),
        .mode     (pe_mode_e'(cfg_mode)),
        .opnd_a   (opnd_a),
        .opnd_t   (opnd_t),
        .fu_res   (fu_res),
        .fu_bad   (fu_bad),
        .fu_vld_q (fu_vld_o),
        .fu_q     (fu_q_o),
        .tr_vld_q (tr_vld_o),
        .tr_q     (tr_q_o),
        .err_q    (err_o)
    );

    // Functional-unit-only mode keeps the transfer port silent.
    assert_fu_only_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && cfg_mode == 2'd0) |=> (!tr_vld_o && tr_q_o == '0));

    // Transfer-only mode forwards the selected transfer operand.
    assert_t_only_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && cfg_mode == 2'd1) |=>
        (tr_vld_o && tr_q_o == $past(opnd_t) && !fu_vld_o && !err_o));

    // Double transfer passes operand A and the transfer operand untouched.
    assert_tt_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && cfg_mode == 2'd3) |=>
        (fu_q_o == $past(opnd_a) && tr_q_o == $past(opnd_t) && !err_o));

    // Unsupported opcode in a functional mode: zero result, flag raised.
    assert_bad_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (cfg_mode == 2'd0 || cfg_mode == 2'd2) && !op_legal(KIND, cfg_op)) |=>
        (err_o && fu_vld_o && fu_q_o == '0));

    // A bubble empties the stage one edge later.
    assert_bubble_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!fu_vld_o && !tr_vld_o && !err_o));

endmodule

// File: tb/test_pe_cell.sv
// Directed bench: an add/sub cell and a multiply cell share one stimulus.
module test_pe_cell;

    localparam int DATA_W = 16;
    localparam int MCL    = 2;
    localparam int NSRC   = 2 * (2 * MCL + 1);
    localparam int SEL_W  = $clog2(NSRC);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_vld = 1'b0;
    logic [NSRC*DATA_W-1:0] src_i = '0;
    logic [1:0]             cfg_mode = '0;
    logic [2:0]             cfg_op = '0;
    logic [SEL_W-1:0]       cfg_sel_a = '0, cfg_sel_b = '0, cfg_sel_t = '0;
    logic                   cfg_imm_a = 1'b0, cfg_imm_b = 1'b0, cfg_imm_t = 1'b0;
    logic [DATA_W-1:0]      cfg_imm = '0;

    logic              fu_vld_o, tr_vld_o, err_o;
    logic [DATA_W-1:0] fu_q_o, tr_q_o;
    logic              m_fu_vld, m_tr_vld, m_err;
    logic [DATA_W-1:0] m_fu_q, m_tr_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pe_cell #(.DATA_W(DATA_W), .MCL(MCL), .KIND(0)) i_pe_cell (
        .clk, .rst_n, .in_vld, .src_i, .cfg_mode, .cfg_op,
        .cfg_sel_a, .cfg_sel_b, .cfg_sel_t, .cfg_imm_a, .cfg_imm_b, .cfg_imm_t, .cfg_imm,
        .fu_vld_o, .fu_q_o, .tr_vld_o, .tr_q_o, .err_o
    );

    pe_cell #(.DATA_W(DATA_W), .MCL(MCL), .KIND(1)) i_pe_cell_mul (
        .clk, .rst_n, .in_vld, .src_i, .cfg_mode, .cfg_op,
        .cfg_sel_a, .cfg_sel_b, .cfg_sel_t, .cfg_imm_a, .cfg_imm_b, .cfg_imm_t, .cfg_imm,
        .fu_vld_o(m_fu_vld), .fu_q_o(m_fu_q), .tr_vld_o(m_tr_vld), .tr_q_o(m_tr_q), .err_o(m_err)
    );

    function automatic logic [DATA_W-1:0] srcv(input int k);
        return DATA_W'(16'h1234 + k * 16'h0f1d);
    endfunction

    function automatic logic [DATA_W-1:0] model_add(input int op, input logic [DATA_W-1:0] a,
                                                     input logic [DATA_W-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Apply one valid cycle and wait until the registered result is visible.
    task automatic step(input logic v, input int mode, input int op,
                        input int sa, input int sb, input int st,
                        input logic ia, input logic ib, input logic it);
        @(negedge clk);
        in_vld = v; cfg_mode = 2'(mode); cfg_op = 3'(op);
        cfg_sel_a = SEL_W'(sa); cfg_sel_b = SEL_W'(sb); cfg_sel_t = SEL_W'(st);
        cfg_imm_a = ia; cfg_imm_b = ib; cfg_imm_t = it;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "fu_vld", 32'(fu_vld_o), 0);
        chk("R1", "fu_q", 32'(fu_q_o), 0);
        chk("R1", "tr_vld", 32'(tr_vld_o), 0);
        chk("R1", "tr_q", 32'(tr_q_o), 0);
        chk("R1", "err", 32'(err_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_addsub_ops();
        for (int op = 0; op < 5; op++) begin
            int sa = op;
            int sb = 9 - op;
            step(1'b1, 0, op, sa, sb, 3, 1'b0, 1'b0, 1'b0);
            chk("R4", "add cell result", 32'(fu_q_o), 32'(model_add(op, srcv(sa), srcv(sb))));
            chk("R4", "fu_vld", 32'(fu_vld_o), 1);
            chk("R4", "err", 32'(err_o), 0);
            chk("R7", "tr_vld in mode 0", 32'(tr_vld_o), 0);
            chk("R7", "tr_q in mode 0", 32'(tr_q_o), 0);
        end
        // Subtraction wrap-around: small minus large.
        step(1'b1, 0, 1, 0, 9, 0, 1'b0, 1'b0, 1'b0);
        chk("R4", "sub wrap", 32'(fu_q_o), 32'(DATA_W'(srcv(0) - srcv(9))));
    endtask

    task automatic t_immediate_and_range();
        cfg_imm = 16'hA5C3;
        step(1'b1, 0, 4, 7, 2, 0, 1'b0, 1'b1, 1'b0);
        chk("R2", "imm as B", 32'(fu_q_o), 32'(srcv(7) ^ 16'hA5C3));
        step(1'b1, 1, 0, 0, 0, 5, 1'b0, 1'b0, 1'b1);
        chk("R2", "imm as T", 32'(tr_q_o), 32'h0000A5C3);
        step(1'b1, 0, 3, 12, 4, 0, 1'b0, 1'b0, 1'b0);
        chk("R3", "sel A out of range", 32'(fu_q_o), 32'(srcv(4)));
        step(1'b1, 1, 0, 0, 0, 15, 1'b0, 1'b0, 1'b0);
        chk("R3", "sel T out of range", 32'(tr_q_o), 0);
        chk("R3", "tr_vld still set", 32'(tr_vld_o), 1);
    endtask

    task automatic t_mul_and_bad();
        logic [2*DATA_W-1:0] p;
        step(1'b1, 0, 5, 8, 9, 0, 1'b0, 1'b0, 1'b0);
        p = 32'(srcv(8)) * 32'(srcv(9));
        chk("R5", "mul low half", 32'(m_fu_q), 32'(p[DATA_W-1:0]));
        chk("R5", "mul err", 32'(m_err), 0);
        chk("R6", "add cell op5 err", 32'(err_o), 1);
        chk("R6", "add cell op5 result", 32'(fu_q_o), 0);
        chk("R6", "add cell op5 valid", 32'(fu_vld_o), 1);
        step(1'b1, 2, 7, 1, 2, 6, 1'b0, 1'b0, 1'b0);
        chk("R6", "add cell op7 err", 32'(err_o), 1);
        chk("R6", "mul cell op7 err", 32'(m_err), 1);
        chk("R6", "mul cell op7 result", 32'(m_fu_q), 0);
        step(1'b1, 0, 0, 1, 2, 0, 1'b0, 1'b0, 1'b0);
        chk("R6", "mul cell op0 err", 32'(m_err), 1);
        chk("R6", "add cell op0 clean", 32'(err_o), 0);
    endtask

    task automatic t_modes();
        step(1'b1, 1, 7, 2, 3, 6, 1'b0, 1'b0, 1'b0);
        chk("R8", "T only tr_q", 32'(tr_q_o), 32'(srcv(6)));
        chk("R8", "T only fu_vld", 32'(fu_vld_o), 0);
        chk("R8", "T only fu_q", 32'(fu_q_o), 0);
        chk("R8", "T only err", 32'(err_o), 0);
        step(1'b1, 2, 0, 2, 3, 8, 1'b0, 1'b0, 1'b0);
        chk("R9", "FU+T result", 32'(fu_q_o), 32'(DATA_W'(srcv(2) + srcv(3))));
        chk("R9", "FU+T tr_q", 32'(tr_q_o), 32'(srcv(8)));
        chk("R9", "FU+T valids", 32'({fu_vld_o, tr_vld_o}), 3);
        step(1'b1, 3, 6, 4, 5, 1, 1'b0, 1'b0, 1'b0);
        chk("R10", "TT fu_q", 32'(fu_q_o), 32'(srcv(4)));
        chk("R10", "TT tr_q", 32'(tr_q_o), 32'(srcv(1)));
        chk("R10", "TT valids", 32'({fu_vld_o, tr_vld_o}), 3);
        chk("R10", "TT err", 32'(err_o), 0);
        chk("R10", "TT mul cell fu_q", 32'(m_fu_q), 32'(srcv(4)));
    endtask

    task automatic t_latency_bubble();
        step(1'b1, 2, 3, 5, 6, 7, 1'b0, 1'b0, 1'b0);
        step(1'b0, 2, 3, 5, 6, 7, 1'b0, 1'b0, 1'b0);
        chk("R11", "bubble fu_vld", 32'(fu_vld_o), 0);
        chk("R11", "bubble tr_vld", 32'(tr_vld_o), 0);
        chk("R11", "bubble data", 32'({fu_q_o, tr_q_o}), 0);
        // Latency: change inputs and confirm output follows after one edge.
        @(negedge clk);
        in_vld = 1'b1; cfg_mode = 2'd1; cfg_sel_t = SEL_W'(9); cfg_imm_t = 1'b0;
        #1;
        chk("R11", "no change before edge", 32'(tr_q_o), 0);
        @(posedge clk);
        #1;
        chk("R11", "one edge latency", 32'(tr_q_o), 32'(srcv(9)));
        // Reset mid-stream.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "mid-stream reset tr_q", 32'(tr_q_o), 0);
        chk("R1", "mid-stream reset tr_vld", 32'(tr_vld_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        in_vld = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < NSRC; k++) src_i[k*DATA_W +: DATA_W] = srcv(k);
        t_reset();
        t_addsub_ops();
        t_immediate_and_range();
        t_mul_and_bad();
        t_modes();
        t_latency_bubble();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule